// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a small synchronous static RAM. A read can follow a write, and a write can follow a read, on the very next clock with no idle cycle in between. Address, direction, byte enables and write data are all captured on the rising clock edge. The write data lags its command by the same number of cycles that the read data lags its command, so the shared data bus stays full whatever mix of operations is issued.

A static mode input selects one of two read styles. In registered mode the read data leaves an output register. In direct mode it comes straight from the array. Each command can be extended into a four-beat burst with an advance input. The burst walks the two lowest address bits in linear or interleaved order. Three chip selects of mixed polarity allow depth expansion. An asynchronous output enable masks the output at any moment, and a sleep input makes the device ignore new commands.

Top module: `zt_sram`

## Requirements
- R1: A command is accepted only when sel_a_n=0, sel_b=1 and sel_c_n=0. Otherwise the cycle issues no operation.
- R2: In direct mode (mode_pipe=0), a read command captured at edge k drives rvalid=1 and the word on rdata between edge k and edge k+1. A write captured at edge k-1 to the same address is already visible in that read.
- R3: In registered mode (mode_pipe=1), a read command captured at edge k drives rvalid=1 and the word on rdata between edge k+1 and edge k+2.
- R4: Write data is taken from wdata one edge after its command in direct mode and two edges after its command in registered mode.
- R5: Reads and writes may alternate on consecutive edges. In registered mode, a read whose address matches the write issued one edge earlier returns that write's data, merged per byte with the stored word.
- R6: byte_we_n[i]=0 writes bits [9i+8:9i] of the word. Lanes with byte_we_n[i]=1 keep their old contents.
- R7: With order_ilv=0, a selected cycle with adv=1 continues the last command in the same direction. It keeps the upper address bits, and beat n uses low bits (start+n) mod 4. Byte enables are taken fresh on each beat.
- R8: With order_ilv=1, burst beat n uses low address bits start XOR n.
- R9: While oe_n=1, rvalid=0 and rdata=0 at once, without waiting for a clock edge. Releasing oe_n restores the pending output.
- R10: While sleep=1, no new command or burst beat is accepted. A write already issued still takes its late data.
- R11: After reset, rvalid=0 and rdata=0 and no operation is in flight. Array contents are not cleared.
- R12: A cycle with adv=1 before any command has been accepted since reset issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_pipe | input | 1 | Static: 1 registered reads, 0 direct reads |
| order_ilv | input | 1 | Static: 1 interleaved burst order, 0 linear |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_en | input | 1 | Command direction, 1 write, 0 read |
| adv | input | 1 | Continue current burst instead of new command |
| addr | input | ADDR_W | Word address |
| byte_we_n | input | NBYTES | Per-lane write enables, active low |
| wdata | input | NBYTES*BYTE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Ignore new commands |
| rdata | output | NBYTES*BYTE_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid and output enabled |

## Verification
The hardest case to reach from the ports is forwarding in registered mode. This needs a write that is still waiting for its data, followed at once by a read of the same word, with some lanes masked, while the late data is arriving on wdata in the same cycle. Directed runs alternate writes and reads to one address with partial byte enables. Random runs confine addresses to eight words and mix in bursts, deselects, sleep cycles and output-enable pulses. These collisions then recur often in both read modes and both burst orders, and a bench model of the array predicts every output cycle.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

   // low address bits of burst beat n from a start value
   function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                          input logic [1:0] n,
                                          input logic       ilv);
      return ilv ? (start ^ n) : (start + n);
   endfunction

endpackage

// File: rtl/zt_cmd_gen.sv
module zt_cmd_gen #(
   parameter int ADDR_W = 8,
   parameter int NBYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_ok,
   input  logic              sleep,
   input  logic              adv,
   input  logic              wr_en,
   input  logic              order_ilv,
   input  logic [ADDR_W-1:0] addr,
   input  logic [NBYTES-1:0] byte_we_n,
   output logic              op_vld,
   output logic              op_wr,
   output logic [ADDR_W-1:0] op_addr,
   output logic [NBYTES-1:0] op_be
);
   import zt_sram_pkg::*;

   logic              b_act, b_wr;
   logic [ADDR_W-1:0] b_base;
   logic [1:0]        b_cnt, nxt_cnt, prev_lo;
   logic              take, new_cmd, is_beat;

   always_comb begin
      take    = sel_ok && !sleep;
      new_cmd = take && !adv;
      is_beat = take && adv && b_act;
      nxt_cnt = b_cnt + 2'd1;
      op_vld  = new_cmd || is_beat;
      op_wr   = new_cmd ? wr_en : b_wr;
      op_addr = new_cmd ? addr
                        : {b_base[ADDR_W-1:2], beat_lo(b_base[1:0], nxt_cnt, order_ilv)};
      op_be   = ~byte_we_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_act   <= 1'b0;
         b_wr    <= 1'b0;
         b_base  <= '0;
         b_cnt   <= '0;
         prev_lo <= '0;
      end else begin
         if (new_cmd) begin
            b_act  <= 1'b1;
            b_wr   <= wr_en;
            b_base <= addr;
            b_cnt  <= '0;
         end else if (is_beat) begin
            b_cnt  <= nxt_cnt;
         end
         if (op_vld) prev_lo <= op_addr[1:0];
      end
   end

   // consecutive linear beats step the low bits by one, wrapping
   assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_beat && !order_ilv) |-> (op_addr[1:0] == prev_lo + 2'd1));

endmodule

// File: rtl/zt_array.sv
module zt_array #(
   parameter int ADDR_W = 8,
   parameter int BYTE_W = 9,
   parameter int NBYTES = 2
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic [NBYTES-1:0]        wbe,
   input  logic [NBYTES*BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]        raddr,
   output logic [NBYTES*BYTE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      logic [BYTE_W-1:0] cells [DEPTH];
      always_ff @(posedge clk) begin
         if (we && wbe[g]) cells[waddr] <= wdata[g*BYTE_W +: BYTE_W];
      end
      assign rdata[g*BYTE_W +: BYTE_W] = cells[raddr];
   end

endmodule

// File: rtl/zt_datapath.sv
module zt_datapath #(
   parameter int ADDR_W = 8,
   parameter int BYTE_W = 9,
   parameter int NBYTES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mode_pipe,
   input  logic                     op_vld,
   input  logic                     op_wr,
   input  logic [ADDR_W-1:0]        op_addr,
   input  logic [NBYTES-1:0]        op_be,
   input  logic [NBYTES*BYTE_W-1:0] wdata,
   output logic                     data_vld,
   output logic [NBYTES*BYTE_W-1:0] data_out
);
   localparam int DW = NBYTES * BYTE_W;

   logic              s1_vld, s1_wr, s2_vld, s2_wr;
   logic [ADDR_W-1:0] s1_addr, s2_addr;
   logic [NBYTES-1:0] s1_be, s2_be;
   logic              we, fwd_hit;
   logic [ADDR_W-1:0] waddr;
   logic [NBYTES-1:0] wbe;
   logic [DW-1:0]     arr_q, merged, out_q;
   logic              out_vld_q;

   // command stages: stage 1 holds the op of the last edge, stage 2 the one before
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld <= 1'b0; s1_wr <= 1'b0; s1_addr <= '0; s1_be <= '0;
         s2_vld <= 1'b0; s2_wr <= 1'b0; s2_addr <= '0; s2_be <= '0;
      end else begin
         s1_vld <= op_vld; s1_wr <= op_wr; s1_addr <= op_addr; s1_be <= op_be;
         s2_vld <= s1_vld; s2_wr <= s1_wr; s2_addr <= s1_addr; s2_be <= s1_be;
      end
   end

   // late write: one stage deep in direct mode, two in registered mode
   always_comb begin
      we    = mode_pipe ? (s2_vld && s2_wr) : (s1_vld && s1_wr);
      waddr = mode_pipe ? s2_addr : s1_addr;
      wbe   = mode_pipe ? s2_be   : s1_be;
   end

   zt_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_array (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wbe   (wbe),
      .wdata (wdata),
      .raddr (s1_addr),
      .rdata (arr_q)
   );

   // forwarding of the write landing on the same edge as the output register load
   assign fwd_hit = s2_vld && s2_wr && (s2_addr == s1_addr);

   for (genvar g = 0; g < NBYTES; g++) begin : g_fwd
      assign merged[g*BYTE_W +: BYTE_W] = (fwd_hit && s2_be[g]) ? wdata[g*BYTE_W +: BYTE_W]
                                                               : arr_q[g*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld_q <= 1'b0;
         out_q     <= '0;
      end else begin
         out_vld_q <= s1_vld && !s1_wr;
         out_q     <= merged;
      end
   end

   assign data_vld = mode_pipe ? out_vld_q : (s1_vld && !s1_wr);
   assign data_out = mode_pipe ? out_q     : arr_q;

   assert_pipe_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_pipe && s1_vld && !s1_wr) |=> data_vld);

   assert_fwd_full_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_pipe && s1_vld && !s1_wr && s2_vld && s2_wr && (s2_addr == s1_addr) && (&s2_be))
      |=> (data_out == $past(wdata)));

endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
   parameter int ADDR_W = 8,
   parameter int BYTE_W = 9,
   parameter int NBYTES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mode_pipe,
   input  logic                     order_ilv,
   input  logic                     sel_a_n,
   input  logic                     sel_b,
   input  logic                     sel_c_n,
   input  logic                     wr_en,
   input  logic                     adv,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [NBYTES-1:0]        byte_we_n,
   input  logic [NBYTES*BYTE_W-1:0] wdata,
   input  logic                     oe_n,
   input  logic                     sleep,
   output logic [NBYTES*BYTE_W-1:0] rdata,
   output logic                     rvalid
);
   localparam int DW = NBYTES * BYTE_W;

   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("zt_sram: ADDR_W must lie in 2..12");
   end
   if (BYTE_W < 1 || NBYTES < 1) begin : g_bad_lane
      $error("zt_sram: BYTE_W and NBYTES must be positive");
   end

   logic              sel_ok;
   logic              op_vld, op_wr;
   logic [ADDR_W-1:0] op_addr;
   logic [NBYTES-1:0] op_be;
   logic              data_vld;
   logic [DW-1:0]     data_out;

   assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

   zt_cmd_gen #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_ok    (sel_ok),
      .sleep     (sleep),
      .adv       (adv),
      .wr_en     (wr_en),
      .order_ilv (order_ilv),
      .addr      (addr),
      .byte_we_n (byte_we_n),
      .op_vld    (op_vld),
      .op_wr     (op_wr),
      .op_addr   (op_addr),
      .op_be     (op_be)
   );

   zt_datapath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_pipe (mode_pipe),
      .op_vld    (op_vld),
      .op_wr     (op_wr),
      .op_addr   (op_addr),
      .op_be     (op_be),
      .wdata     (wdata),
      .data_vld  (data_vld),
      .data_out  (data_out)
   );

   // output drivers gated asynchronously
   assign rvalid = data_vld && !oe_n;
   assign rdata  = rvalid ? data_out : '0;

   assert_deselect_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_ok && !mode_pipe) |=> !data_vld);

   assert_sleep_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep && !mode_pipe) |=> !data_vld);

endmodule

// File: tb/zt_sram_bench.sv
`timescale 1ns/1ps
module zt_sram_bench;
   localparam int AW = 8;
   localparam int BW = 9;
   localparam int NB = 2;
   localparam int DW = NB * BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_pipe = 1'b0, order_ilv = 1'b0;
   logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
   logic          wr_en = 1'b0, adv = 1'b0, oe_n = 1'b0, sleep = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [NB-1:0] byte_we_n = '1;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rvalid;

   int    n_checks = 0, n_fail = 0;
   bit    done = 1'b0;
   string tag = "R11";

   always #2.5 clk = ~clk;

   zt_sram #(.ADDR_W(AW), .BYTE_W(BW), .NBYTES(NB)) u_zt_sram (
      .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .order_ilv(order_ilv),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_en(wr_en), .adv(adv),
      .addr(addr), .byte_we_n(byte_we_n), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
      .rdata(rdata), .rvalid(rvalid)
   );

   // ---------------- reference model ----------------
   logic [DW-1:0] mmem [1<<AW];
   logic          m1_v, m1_w, m2_v, m2_w, b_act, b_wr, exp_v;
   logic [AW-1:0] m1_a, m2_a, b_base;
   logic [NB-1:0] m1_be, m2_be;
   logic [1:0]    b_cnt;
   logic [DW-1:0] exp_d;

   function automatic logic [1:0] lo_of(input logic [1:0] s, input logic [1:0] n, input logic ilv);
      return ilv ? (s ^ n) : 2'((s + n) & 2'd3);
   endfunction

   task automatic model_reset();
      m1_v = 0; m1_w = 0; m2_v = 0; m2_w = 0; b_act = 0; b_wr = 0; exp_v = 0;
      m1_a = '0; m2_a = '0; b_base = '0; m1_be = '0; m2_be = '0; b_cnt = '0; exp_d = '0;
   endtask

   task automatic commit(input logic [AW-1:0] a, input logic [NB-1:0] be);
      for (int g = 0; g < NB; g++)
         if (be[g]) mmem[a][g*BW +: BW] = wdata[g*BW +: BW];
   endtask

   task automatic model_edge();
      logic take, nv, nw;
      logic [AW-1:0] na;
      take = !sel_a_n && sel_b && !sel_c_n && !sleep;
      nv = 0; nw = 0; na = '0;
      if (take && !adv) begin
         nv = 1; nw = wr_en; na = addr;
         b_act = 1; b_wr = wr_en; b_base = addr; b_cnt = 0;
      end else if (take && adv && b_act) begin
         b_cnt = b_cnt + 2'd1;
         nv = 1; nw = b_wr; na = {b_base[AW-1:2], lo_of(b_base[1:0], b_cnt, order_ilv)};
      end
      if (mode_pipe) begin
         if (m2_v && m2_w) commit(m2_a, m2_be);
         exp_v = m1_v && !m1_w;
         if (exp_v) exp_d = mmem[m1_a];
      end else begin
         if (m1_v && m1_w) commit(m1_a, m1_be);
         exp_v = nv && !nw;
         if (exp_v) exp_d = mmem[na];
      end
      m2_v = m1_v; m2_w = m1_w; m2_a = m1_a; m2_be = m1_be;
      m1_v = nv;   m1_w = nw;   m1_a = na;   m1_be = ~byte_we_n;
   endtask

   task automatic check_out();
      logic          ev;
      logic [DW-1:0] ed;
      ev = exp_v && !oe_n;
      ed = ev ? exp_d : '0;
      n_checks++;
      if (rvalid !== ev || rdata !== ed) begin
         n_fail++;
         $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h", tag, rvalid, rdata, ev, ed);
      end
   endtask

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_out();
   endtask

   task automatic op(input logic w, input logic [AW-1:0] a, input logic [NB-1:0] bwe_n);
      sel_a_n = 0; sel_b = 1; sel_c_n = 0; adv = 0;
      wr_en = w; addr = a; byte_we_n = bwe_n; wdata = DW'($urandom);
      tick();
   endtask

   task automatic beat(input logic [NB-1:0] bwe_n);
      sel_a_n = 0; sel_b = 1; sel_c_n = 0; adv = 1;
      byte_we_n = bwe_n; wdata = DW'($urandom); addr = AW'($urandom);
      tick();
   endtask

   task automatic nop();
      sel_b = 0; adv = 0; wr_en = 0; wdata = DW'($urandom);
      tick();
   endtask

   task automatic do_reset(input logic pipe, input logic ilv);
      sel_b = 0; adv = 0; sleep = 0; oe_n = 0;
      rst_n = 0; mode_pipe = pipe; order_ilv = ilv;
      repeat (3) @(posedge clk);
      model_reset();
      @(negedge clk);
      rst_n = 1;
      tag = "R11";
      n_checks++;
      if (rvalid !== 1'b0 || rdata !== '0) begin
         n_fail++;
         $display("FAIL R11: rvalid=%0b rdata=%h expected rvalid=0 rdata=0", rvalid, rdata);
      end
   endtask

   task automatic oe_probe();
      oe_n = 1; #1;
      n_checks++;
      if (rvalid !== 1'b0 || rdata !== '0) begin
         n_fail++;
         $display("FAIL R9: rvalid=%0b rdata=%h expected rvalid=0 rdata=0", rvalid, rdata);
      end
      oe_n = 0; #0.5;
      check_out();
   endtask

   task automatic random_run(input int n);
      for (int i = 0; i < n; i++) begin
         sel_a_n   = ($urandom % 20) == 0;
         sel_b     = ($urandom % 20) != 0;
         sel_c_n   = ($urandom % 20) == 0;
         sleep     = ($urandom % 25) == 0;
         oe_n      = ($urandom % 12) == 0;
         adv       = ($urandom % 100) < 35;
         wr_en     = ($urandom % 2) == 1;
         addr      = 8'h60 | AW'($urandom % 8);
         byte_we_n = NB'($urandom);
         wdata     = DW'($urandom);
         tick();
      end
      oe_n = 0; sleep = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2718));
      @(negedge clk);
      do_reset(1'b0, 1'b0);

      // R12: advance before any accepted command issues nothing
      tag = "R12";
      wr_en = 0; beat(2'b00); beat(2'b00); nop();

      // fill every word with known data (direct mode, back-to-back writes)
      tag = "R4";
      for (int a = 0; a < (1 << AW); a++) op(1'b1, AW'(a), 2'b00);
      nop();

      // R2: direct read latency, read right after write
      tag = "R2";
      op(1'b1, 8'h10, 2'b00); op(1'b0, 8'h10, 2'b00); op(1'b0, 8'h11, 2'b00); nop(); nop();
      // R4: late write in direct mode, alternating
      tag = "R4";
      op(1'b1, 8'h12, 2'b00); op(1'b1, 8'h13, 2'b00); op(1'b0, 8'h12, 2'b00); op(1'b0, 8'h13, 2'b00); nop();
      // R6: byte lanes
      tag = "R6";
      op(1'b1, 8'h14, 2'b10); op(1'b0, 8'h14, 2'b11); op(1'b1, 8'h14, 2'b01); op(1'b0, 8'h14, 2'b11); nop();
      // R1: each select inactive in turn
      tag = "R1";
      op(1'b0, 8'h15, 2'b11); nop();
      sel_a_n = 1; sel_b = 1; sel_c_n = 0; adv = 0; wr_en = 0; addr = 8'h15; tick();
      sel_a_n = 0; sel_b = 0; sel_c_n = 0; tick();
      sel_a_n = 0; sel_b = 1; sel_c_n = 1; tick();
      sel_c_n = 0; wr_en = 1; sel_a_n = 1; tick(); nop();
      op(1'b0, 8'h15, 2'b11); nop();
      // R9: output enable masks asynchronously
      tag = "R9";
      op(1'b0, 8'h16, 2'b11); oe_probe(); nop();

      // registered mode
      do_reset(1'b1, 1'b0);
      tag = "R3";
      op(1'b1, 8'h20, 2'b00); nop(); nop(); op(1'b0, 8'h20, 2'b11); nop(); nop(); nop();
      tag = "R4";
      op(1'b1, 8'h21, 2'b00); op(1'b1, 8'h22, 2'b00); nop(); op(1'b0, 8'h21, 2'b11); op(1'b0, 8'h22, 2'b11); nop(); nop();
      tag = "R5";
      for (int i = 0; i < 6; i++) begin
         op(1'b1, 8'h30, 2'b00); op(1'b0, 8'h30, 2'b11);
      end
      op(1'b1, 8'h31, 2'b01); op(1'b0, 8'h31, 2'b11); op(1'b1, 8'h31, 2'b10); op(1'b0, 8'h31, 2'b11); nop(); nop();
      tag = "R10";
      op(1'b1, 8'h50, 2'b00); sleep = 1; op(1'b0, 8'h50, 2'b11); op(1'b1, 8'h51, 2'b00); beat(2'b00);
      sleep = 0; nop(); nop(); op(1'b0, 8'h50, 2'b11); op(1'b0, 8'h51, 2'b11); nop(); nop();
      tag = "R9";
      op(1'b0, 8'h50, 2'b11); nop(); oe_probe(); nop();
      tag = "R7";
      op(1'b1, 8'h42, 2'b00); beat(2'b00); beat(2'b10); beat(2'b00); beat(2'b00);
      op(1'b0, 8'h43, 2'b11); beat(2'b11); beat(2'b11); beat(2'b11); beat(2'b11); nop(); nop();

      do_reset(1'b1, 1'b1);
      tag = "R8";
      op(1'b1, 8'h4B, 2'b00); beat(2'b00); beat(2'b00); beat(2'b00);
      op(1'b0, 8'h49, 2'b11); beat(2'b11); beat(2'b11); beat(2'b11); nop(); nop();

      do_reset(1'b0, 1'b1);
      tag = "R8";
      op(1'b1, 8'h5E, 2'b00); beat(2'b00); beat(2'b01); beat(2'b00);
      op(1'b0, 8'h5C, 2'b11); beat(2'b11); beat(2'b11); beat(2'b11); nop();
      tag = "R7";
      do_reset(1'b0, 1'b0);
      op(1'b0, 8'h5D, 2'b11); beat(2'b11); beat(2'b11); beat(2'b11); beat(2'b11); nop();

      // constrained random in every mode combination
      tag = "R5";
      do_reset(1'b0, 1'b0); tag = "R5"; random_run(1500);
      do_reset(1'b1, 1'b0); tag = "R5"; random_run(1500);
      do_reset(1'b0, 1'b1); tag = "R5"; random_run(1500);
      do_reset(1'b1, 1'b1); tag = "R5"; random_run(1500);
      nop(); nop();
      finish_run();
   end

endmodule